// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Engine

This block moves one byte at a time over a two-wire synchronous link in half-duplex. One wire is a bidirectional data line (output value, output enable and input sample are separate ports so the pad can live elsewhere); the other is a shift clock that the block always drives. The block runs on the oscillator clock and derives every edge of the shift clock by counting oscillator periods, so a bit cell is exactly twelve periods long: the shift clock sits low for ten periods and high for two.

Software starts a transmit by writing a byte (`tx_wr` with `tx_byte`). It starts a receive by holding `rx_en` while the receive-done flag is clear. Bits travel least-significant first. When a frame completes the matching done flag sets and stays set until its clear input is pulsed; while a done flag is set, a new frame of that direction cannot begin. Between frames the shift clock rests high and the data line is released.

Top module: `ssm_shift_engine`

## Requirements
- R1: After reset, `sclk` is 1, `sd_oe` is 0, `sd_out` is 1, and both `tx_done` and `rx_done` are 0.
- R2: A transmit frame puts the eight bits of `tx_byte` on `sd_out` least-significant bit first, one bit per shift-clock cycle.
- R3: Every bit cell of a frame lasts 12 clock cycles: `sclk` is low for 10 cycles and then high for 2.
- R4: During a transmit, `sd_out` changes only on the cycle where `sclk` falls, so each bit is valid for the 10 low cycles before the rising edge and held for the 2 high cycles after it.
- R5: `tx_done` rises 96 cycles after the clock edge that accepts `tx_wr`, then stays 1 until `tx_done_clr` is pulsed, after which it reads 0.
- R6: A start request is ignored while the done flag of the same direction is set: `tx_wr` with `tx_done`=1 or `rx_en` with `rx_done`=1 leaves `sclk` high and `sd_oe` low.
- R7: A `tx_wr` during an active frame is ignored; the frame in progress sends its original byte and no second frame follows.
- R8: A receive frame samples `sd_in` at each rising edge of `sclk`, assembles the byte least-significant bit first, and after the eighth sample presents it on `rx_byte` with `rx_done` set.
- R9: Outside a transmit frame the data line is released (`sd_oe`=0), including during a receive, and when no frame is active `sclk` is 1.
- R10: When `tx_wr` and `rx_en` are both requested in the same idle cycle, the transmit frame starts and the receive does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | One-cycle request to send `tx_byte` |
| tx_byte | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable; starts a receive when idle and `rx_done` is clear |
| tx_done_clr | input | 1 | Clears the transmit-done flag |
| rx_done_clr | input | 1 | Clears the receive-done flag |
| sd_in | input | 1 | Data line as seen at the pad |
| sd_out | output | 1 | Data line drive value |
| sd_oe | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock |
| rx_byte | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |

## Verification
A phase or bit counter that drifts shows up on `sclk` within one bit cell as a low or high interval other than 10 or 2 cycles, and as a frame that ends early or late, moving the `tx_done` edge off cycle 96. A transmit shift register that slips shows as a wrong bit at the very next rising edge, and a data change outside the falling edge breaks the setup or hold window within that cell. A mode register that fails to return to idle or restarts on a blocked request shows as extra shift-clock pulses after the done flag is set, which the bench treats as an unexpected frame.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    SX_IDLE = 2'd0,
    SX_TX   = 2'd1,
    SX_RX   = 2'd2
  } sx_mode_e;
endpackage

// File: rtl/ssm_bit_timer.sv
module ssm_bit_timer #(
  parameter int CELL_CYC = 12,
  parameter int LOW_CYC  = 10,
  parameter int NBITS    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic rise_stb,
  output logic cell_end,
  output logic last_bit
);
  localparam int PH_W  = (CELL_CYC > 1) ? $clog2(CELL_CYC) : 1;
  localparam int BIT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CELL_CYC - 1);
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(LOW_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NBITS - 1);

  logic [PH_W-1:0]  phase_q;
  logic [BIT_W-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else if (start) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else if (run) begin
      if (phase_q == PH_LAST) begin
        phase_q <= '0;
        bit_q   <= bit_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign rise_stb = run && (phase_q == PH_RISE);
  assign cell_end = run && (phase_q == PH_LAST);
  assign last_bit = (bit_q == BIT_LAST);

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q <= PH_LAST);

  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_q <= BIT_LAST);
endmodule

// File: rtl/ssm_shift_path.sv
module ssm_shift_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] tx_in,
  input  logic              tx_act,
  input  logic              rx_act,
  input  logic              rise_stb,
  input  logic              cell_end,
  input  logic              last_bit,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [DATA_W-1:0] rx_next;
  logic              sd_out_q;
  logic              sd_oe_q;
  logic [DATA_W-1:0] rx_byte_q;

  assign rx_next = {sd_in, rx_sh_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh_q  <= '0;
      sd_out_q <= 1'b1;
      sd_oe_q  <= 1'b0;
    end else if (load_tx) begin
      tx_sh_q  <= tx_in >> 1;
      sd_out_q <= tx_in[0];
      sd_oe_q  <= 1'b1;
    end else if (tx_act && cell_end) begin
      if (last_bit) begin
        sd_out_q <= 1'b1;
        sd_oe_q  <= 1'b0;
      end else begin
        sd_out_q <= tx_sh_q[0];
        tx_sh_q  <= tx_sh_q >> 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh_q   <= '0;
      rx_byte_q <= '0;
    end else if (rx_act && rise_stb) begin
      rx_sh_q <= rx_next;
      if (last_bit) rx_byte_q <= rx_next;
    end
  end

  assign sd_out  = sd_out_q;
  assign sd_oe   = sd_oe_q;
  assign rx_byte = rx_byte_q;

  // R9
  oe_only_tx_chk: assert property (@(posedge clk) disable iff (rst)
    sd_oe_q |-> tx_act);
endmodule

// File: rtl/ssm_shift_engine.sv
module ssm_shift_engine #(
  parameter int DATA_W   = 8,
  parameter int CELL_CYC = 12,
  parameter int LOW_CYC  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_en,
  input  logic              tx_done_clr,
  input  logic              rx_done_clr,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              sclk,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_done,
  output logic              rx_done
);
  import ssm_pkg::*;

  sx_mode_e mode_q;
  logic     sclk_q;
  logic     tx_done_q;
  logic     rx_done_q;
  logic     run;
  logic     start_tx;
  logic     start_rx;
  logic     rise_stb;
  logic     cell_end;
  logic     last_bit;
  logic     frame_end;
  logic     sd_out_w;
  logic     sd_oe_w;

  assign run       = (mode_q != SX_IDLE);
  assign start_tx  = (mode_q == SX_IDLE) && tx_wr && !tx_done_q;
  assign start_rx  = (mode_q == SX_IDLE) && !start_tx && rx_en && !rx_done_q;
  assign frame_end = cell_end && last_bit;

  ssm_bit_timer #(
    .CELL_CYC (CELL_CYC),
    .LOW_CYC  (LOW_CYC),
    .NBITS    (DATA_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start_tx || start_rx),
    .run      (run),
    .rise_stb (rise_stb),
    .cell_end (cell_end),
    .last_bit (last_bit)
  );

  ssm_shift_path #(
    .DATA_W (DATA_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .load_tx  (start_tx),
    .tx_in    (tx_byte),
    .tx_act   (mode_q == SX_TX),
    .rx_act   (mode_q == SX_RX),
    .rise_stb (rise_stb),
    .cell_end (cell_end),
    .last_bit (last_bit),
    .sd_in    (sd_in),
    .sd_out   (sd_out_w),
    .sd_oe    (sd_oe_w),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SX_IDLE;
    end else if (start_tx) begin
      mode_q <= SX_TX;
    end else if (start_rx) begin
      mode_q <= SX_RX;
    end else if (frame_end) begin
      mode_q <= SX_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
    end else if (start_tx || start_rx) begin
      sclk_q <= 1'b0;
    end else if (rise_stb) begin
      sclk_q <= 1'b1;
    end else if (cell_end && !last_bit) begin
      sclk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
    end else begin
      if (mode_q == SX_TX && frame_end) tx_done_q <= 1'b1;
      else if (tx_done_clr)             tx_done_q <= 1'b0;
      if (mode_q == SX_RX && rise_stb && last_bit) rx_done_q <= 1'b1;
      else if (rx_done_clr)                        rx_done_q <= 1'b0;
    end
  end

  assign sd_out  = sd_out_w;
  assign sd_oe   = sd_oe_w;
  assign sclk    = sclk_q;
  assign tx_done = tx_done_q;
  assign rx_done = rx_done_q;

  // R9
  idle_sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SX_IDLE) |-> sclk_q);

  // R4
  data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == SX_TX) && ($past(mode_q) == SX_TX) && !$stable(sd_out_w)) |-> $fell(sclk_q));

  // R5
  tx_done_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done_q) |-> ($past(mode_q) == SX_TX));

  // R6
  tx_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == SX_IDLE) && tx_done_q) |=> (mode_q != SX_TX));

  // R6
  rx_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == SX_IDLE) && rx_done_q) |=> (mode_q != SX_RX));
endmodule

// File: tb/ssm_shift_engine_test.sv
module ssm_shift_engine_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       rx_en = 1'b0;
  logic       tx_done_clr = 1'b0;
  logic       rx_done_clr = 1'b0;
  logic       sd_in = 1'b1;
  logic       sd_out, sd_oe, sclk, tx_done, rx_done;
  logic [7:0] rx_byte;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #5 clk = ~clk;

  ssm_shift_engine uut (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_en(rx_en),
    .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr), .sd_in(sd_in),
    .sd_out(sd_out), .sd_oe(sd_oe), .sclk(sclk), .rx_byte(rx_byte),
    .tx_done(tx_done), .rx_done(rx_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: reconstructs frames from the pins and compares against the queues.
  logic       prev_sclk = 1'b1;
  int         lo_cnt = 0;
  int         hi_cnt = 0;
  int         nb = 0;
  logic [7:0] acc = 8'h00;
  logic       cell_d = 1'b1;
  bit         stab_bad = 1'b0;
  bit         was_tx = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      prev_sclk = 1'b1; nb = 0; lo_cnt = 0; hi_cnt = 0;
    end else begin
      if (!sclk) begin
        if (prev_sclk) begin
          if (nb > 0 && nb < 8) chk(hi_cnt == 2, "R3 high time", hi_cnt, 2);
          lo_cnt = 0;
          if (nb == 0) begin stab_bad = 1'b0; was_tx = sd_oe; end
        end
        lo_cnt++;
        if (sd_oe) begin
          if (lo_cnt == 1) cell_d = sd_out;
          else if (sd_out !== cell_d) stab_bad = 1'b1;
        end
      end else if (!prev_sclk) begin
        chk(lo_cnt == 10, "R3 low time", lo_cnt, 10);
        if (was_tx && sd_out !== cell_d) stab_bad = 1'b1;
        acc[nb] = was_tx ? sd_out : sd_in;
        nb++;
        hi_cnt = 1;
      end else begin
        hi_cnt++;
        if (nb > 0 && hi_cnt == 2) begin
          if (was_tx && sd_out !== cell_d) stab_bad = 1'b1;
          if (nb == 8) begin
            if (was_tx) begin
              if (txq.size() == 0) chk(1'b0, "R6/R7 unexpected tx frame", acc, 0);
              else begin
                logic [7:0] e;
                e = txq.pop_front();
                chk(acc == e, "R2 tx byte", acc, e);
                chk(!stab_bad, "R4 data window", stab_bad, 0);
              end
            end else begin
              if (rxq.size() == 0) chk(1'b0, "R6 unexpected rx frame", 0, 0);
              else begin
                logic [7:0] e;
                e = rxq.pop_front();
                chk(rx_byte == e, "R8 rx byte", rx_byte, e);
                chk(rx_done == 1'b1, "R8 rx_done", rx_done, 1);
              end
            end
            nb = 0;
          end
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic send(input logic [7:0] b, input bit expect_frame);
    @(negedge clk);
    tx_byte = b; tx_wr = 1'b1;
    if (expect_frame) txq.push_back(b);
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic clear_tx();
    @(negedge clk); tx_done_clr = 1'b1;
    @(negedge clk); tx_done_clr = 1'b0;
  endtask

  task automatic clear_rx();
    @(negedge clk); rx_done_clr = 1'b1;
    @(negedge clk); rx_done_clr = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] b);
    sd_in = b[0];
    rxq.push_back(b);
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk); rx_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      while (sclk !== 1'b0) @(negedge clk);
      sd_in = b[k];
      if (k == 3) chk(sd_oe == 1'b0, "R9 line released in rx", sd_oe, 0);
      while (sclk !== 1'b1) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic tx_and_wait(input logic [7:0] b);
    send(b, 1'b1);
    repeat (96) @(negedge clk);
    chk(tx_done == 1'b1, "R5 tx_done set", tx_done, 1);
    clear_tx();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(sclk == 1'b1, "R1 sclk idle", sclk, 1);
    chk(sd_oe == 1'b0, "R1 oe idle", sd_oe, 0);
    chk(sd_out == 1'b1, "R1 sd_out idle", sd_out, 1);
    chk(tx_done == 1'b0 && rx_done == 1'b0, "R1 flags", {tx_done, rx_done}, 0);

    // R5: exact done timing and hold
    send(8'hA5, 1'b1);
    repeat (95) @(negedge clk);
    chk(tx_done == 1'b0, "R5 tx_done early", tx_done, 0);
    @(negedge clk);
    chk(tx_done == 1'b1, "R5 tx_done at 96", tx_done, 1);
    chk(sd_oe == 1'b0 && sclk == 1'b1, "R9 idle after tx", {sd_oe, sclk}, 1);
    repeat (20) @(negedge clk);
    chk(tx_done == 1'b1, "R5 tx_done holds", tx_done, 1);
    clear_tx();
    chk(tx_done == 1'b0, "R5 tx_done cleared", tx_done, 0);

    // R2 R3 R4 across patterns
    tx_and_wait(8'h3C);
    tx_and_wait(8'h01);
    tx_and_wait(8'h80);
    tx_and_wait(8'hFF);
    tx_and_wait(8'h00);

    // R6: write while tx_done set is ignored
    send(8'h11, 1'b1);
    repeat (96) @(negedge clk);
    send(8'h5A, 1'b0);
    repeat (30) @(negedge clk);
    chk(sclk == 1'b1 && sd_oe == 1'b0, "R6 tx blocked", {sclk, sd_oe}, 2);
    chk(tx_done == 1'b1, "R6 tx_done kept", tx_done, 1);
    clear_tx();

    // R7: write during active frame is ignored
    send(8'h96, 1'b1);
    repeat (40) @(negedge clk);
    send(8'h69, 1'b0);
    repeat (54) @(negedge clk);
    chk(tx_done == 1'b1, "R7 first frame done", tx_done, 1);
    clear_tx();
    repeat (30) @(negedge clk);
    chk(sclk == 1'b1 && sd_oe == 1'b0, "R7 no second frame", {sclk, sd_oe}, 2);

    // R8 receive
    rx_frame(8'hC3);
    chk(rx_done == 1'b1, "R8 rx_done set", rx_done, 1);
    // R6: rx_en while rx_done set
    @(negedge clk); rx_en = 1'b1;
    repeat (30) @(negedge clk);
    chk(sclk == 1'b1, "R6 rx blocked", sclk, 1);
    rx_en = 1'b0;
    clear_rx();
    chk(rx_done == 1'b0, "R8 rx_done cleared", rx_done, 0);
    rx_frame(8'h2D);
    clear_rx();

    // R10: tx wins over simultaneous rx
    @(negedge clk);
    tx_byte = 8'h7E; tx_wr = 1'b1; rx_en = 1'b1;
    txq.push_back(8'h7E);
    @(negedge clk);
    tx_wr = 1'b0; rx_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(sd_oe == 1'b1, "R10 tx chosen", sd_oe, 1);
    repeat (92) @(negedge clk);
    chk(tx_done == 1'b1 && rx_done == 1'b0, "R10 flags", {tx_done, rx_done}, 2);
    clear_tx();
    repeat (10) @(negedge clk);

    chk(txq.size() == 0 && rxq.size() == 0, "R2 all frames seen", txq.size() + rxq.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule